// File: doc/BRIEF.md
# Paravirtual Queue Configuration Register File

This block is the common configuration window of a paravirtual PCI function. A host driver reaches it through a simple register bus with a byte address, 32-bit data and byte enables. Through it the driver reads the device's 64 offered feature bits, writes back the 64 bits it accepts, sets a configuration-change interrupt vector and a status byte, and programs every queue the device offers.

The feature bits and the per-queue registers are too many to map flat. They are reached instead through select registers that open a window onto one 32-bit feature half or onto one queue. The per-queue registers are size, interrupt vector, enable, a read-only notify offset and three 64-bit ring addresses. The whole per-queue state, the negotiated features, the status byte and the configuration vector drive ports that the rest of the device consumes. Writing zero to the status byte resets the function and raises a one-cycle reset pulse.

Top module: `vq_cfg_regs`

## Requirements
- R1: Word address `addr[5:2]` selects the register word. The words are: 0 offered-feature select, 1 offered features (read-only), 2 accepted-feature select, 3 accepted features, 4 config vector in bits 15:0 and queue count in bits 31:16 (read-only), 5 status in bits 7:0 and queue select in bits 31:16, 6 queue size in bits 15:0 and queue vector in bits 31:16, 7 queue enable in bit 0 and notify offset in bits 31:16 (read-only), and 8 to 13 the low and high halves of the descriptor, available and used ring addresses. Unmapped words read zero.
- R2: An offered-feature select of 0 shows feature bits 31:0 and a select of 1 shows bits 63:32. Any other select reads the offered-feature word as zero.
- R3: An accepted-feature select of 0 or 1 opens the low or high half of the accepted features for reads and writes. Any other select drops writes to that word and reads it as zero. The 64 accepted bits appear on `drv_feat_o`.
- R4: A queue size write takes effect only if the value is zero, or is a power of two not above QMAX. Any other value leaves the size unchanged. The size comes out of reset at QMAX.
- R5: A vector write, to either the config vector or a queue vector, stores the value if it is below NUM_VEC and stores 0xFFFF otherwise. Both vectors reset to 0xFFFF.
- R6: Queue select picks the queue that words 6 to 13 address. Enable and the ring-address halves written there appear on that queue's slot of the packed per-queue outputs and read back.
- R7: While queue select is at or above the queue count, words 6 to 13 read zero and writes to them change no queue.
- R8: The queue count reads as NQ, and the notify offset of queue i reads as i.
- R9: A write of zero to the status byte clears the status, the accepted features and every queue to its reset state (size QMAX, vector 0xFFFF, disabled, addresses zero). The config vector and both selects are kept. `dev_reset_o` is high for the one cycle after that write. A nonzero status write stores the value without a pulse.
- R10: A field is written only when every byte enable that covers it is set: all four for 32-bit words, `be[1:0]` for a low 16-bit field, `be[3:2]` for a high one, and `be[0]` for status.
- R11: A read presented with `rd_en` returns `rd_data` with `rd_valid` high in the next cycle. `rd_valid` stays low in a cycle that follows no read.
- R12: After hardware reset the status is zero, no queue is enabled, every queue size is QMAX and `dev_reset_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 6 | Byte address, bits 5:2 used |
| wdata | input | 32 | Write data |
| be | input | 4 | Byte enables |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| dev_reset_o | output | 1 | One-cycle function reset pulse |
| dev_status_o | output | 8 | Status byte |
| drv_feat_o | output | 64 | Accepted feature bits |
| cfg_vec_o | output | 16 | Config-change vector |
| q_size_o | output | NQ x 16 | Per-queue size |
| q_vec_o | output | NQ x 16 | Per-queue vector |
| q_en_o | output | NQ | Per-queue enable |
| q_desc_o | output | NQ x 64 | Per-queue descriptor table address |
| q_avail_o | output | NQ x 64 | Per-queue available ring address |
| q_used_o | output | NQ x 64 | Per-queue used ring address |

## Verification
A write lands at the clock edge that ends its strobe cycle. The output ports it touches, including the reset pulse, are therefore due one cycle after the write is presented, and the bench checks them at the falling edge right after that cycle. Read data is due one cycle after `rd_en`. The driver pushes the expected word into a scoreboard queue when it raises `rd_en`. The monitor pops and compares an entry only at a falling edge where `rd_valid` is high, and a valid word with nothing queued counts as a failure. The pulse is also checked to have dropped one cycle later.

// File: rtl/vq_cfg_pkg.sv
// Shared word map, per-queue field strobes and value filters for the
// queue configuration register file. Assumes a 32-bit register bus.
package vq_cfg_pkg;

    localparam logic [15:0] NO_VEC = 16'hFFFF;

    // Register word index taken from addr[5:2]
    typedef enum logic [3:0] {
        W_DFSEL  = 4'd0,
        W_DFEAT  = 4'd1,
        W_GFSEL  = 4'd2,
        W_GFEAT  = 4'd3,
        W_MISC   = 4'd4,
        W_STAT   = 4'd5,
        W_QSZV   = 4'd6,
        W_QENO   = 4'd7,
        W_DESC_L = 4'd8,
        W_DESC_H = 4'd9,
        W_AVL_L  = 4'd10,
        W_AVL_H  = 4'd11,
        W_USD_L  = 4'd12,
        W_USD_H  = 4'd13,
        W_RSV0   = 4'd14,
        W_RSV1   = 4'd15
    } word_e;

    // Bit positions of the per-queue write strobe vector
    localparam int QB_SIZE   = 0;
    localparam int QB_VEC    = 1;
    localparam int QB_EN     = 2;
    localparam int QB_DESC_L = 3;
    localparam int QB_DESC_H = 4;
    localparam int QB_AVL_L  = 5;
    localparam int QB_AVL_H  = 6;
    localparam int QB_USD_L  = 7;
    localparam int QB_USD_H  = 8;
    localparam int QF_N      = 9;

    // Clamp a vector write: in-range values pass, others become NO_VEC
    function automatic logic [15:0] vec_clean(input logic [15:0] v,
                                              input int unsigned nvec);
        return ({16'd0, v} < nvec) ? v : NO_VEC;
    endfunction

    // A queue size is legal when zero or a power of two up to qmax
    function automatic logic size_ok(input logic [15:0] v,
                                     input int unsigned qmax);
        if (v == 16'd0) return 1'b1;
        return ((v & (v - 16'd1)) == 16'd0) && ({16'd0, v} <= qmax);
    endfunction

endpackage

// File: rtl/vq_feature_window.sv
// Feature negotiation windows: an offered-feature view selected by one
// register and a 64-bit accepted-feature store opened in 32-bit halves
// by another. Assumes write strobes are already decoded and qualified.
module vq_feature_window #(
    parameter logic [63:0] DEV_FEAT = 64'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr_i,
    input  logic        dsel_we,
    input  logic        gsel_we,
    input  logic        gfeat_we,
    input  logic [31:0] wdata,
    output logic [31:0] dsel_rd,
    output logic [31:0] dfeat_rd,
    output logic [31:0] gsel_rd,
    output logic [31:0] gfeat_rd,
    output logic [63:0] drv_feat_o
);

    logic [31:0] dsel_q;
    logic [31:0] gsel_q;
    logic [63:0] gfeat_q;

    // Select registers, kept across a function reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dsel_q <= '0;
            gsel_q <= '0;
        end else begin
            if (dsel_we) dsel_q <= wdata;
            if (gsel_we) gsel_q <= wdata;
        end
    end

    // Accepted features: written through the open half, cleared on function reset
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            gfeat_q <= '0;
        end else if (gfeat_we) begin
            if (gsel_q == 32'd0)      gfeat_q[31:0]  <= wdata;
            else if (gsel_q == 32'd1) gfeat_q[63:32] <= wdata;
        end
    end

    // Read views of the two windows
    always_comb begin
        dsel_rd  = dsel_q;
        gsel_rd  = gsel_q;
        dfeat_rd = (dsel_q == 32'd0) ? DEV_FEAT[31:0] :
                   (dsel_q == 32'd1) ? DEV_FEAT[63:32] : 32'd0;
        gfeat_rd = (gsel_q == 32'd0) ? gfeat_q[31:0] :
                   (gsel_q == 32'd1) ? gfeat_q[63:32] : 32'd0;
    end

    assign drv_feat_o = gfeat_q;

    // R3
    gfeat_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gfeat_we && !clr_i && gsel_q > 32'd1) |=> $stable(gfeat_q));

endmodule

// File: rtl/vq_queue_slot.sv
// State of one queue: size, vector, enable and three ring addresses.
// Assumes the strobes arrive only when this queue is the selected one.
module vq_queue_slot
    import vq_cfg_pkg::*;
#(
    parameter int unsigned QMAX    = 256,
    parameter int unsigned NUM_VEC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic [QF_N-1:0] we_i,
    input  logic [31:0]     wdata,
    output logic [15:0]     size_o,
    output logic [15:0]     vec_o,
    output logic            en_o,
    output logic [63:0]     desc_o,
    output logic [63:0]     avail_o,
    output logic [63:0]     used_o
);

    localparam logic [15:0] SIZE_RST = 16'(QMAX);

    // Field updates, with hardware and function reset to the same values
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            size_o  <= SIZE_RST;
            vec_o   <= NO_VEC;
            en_o    <= 1'b0;
            desc_o  <= '0;
            avail_o <= '0;
            used_o  <= '0;
        end else begin
            if (we_i[QB_SIZE] && size_ok(wdata[15:0], QMAX)) size_o <= wdata[15:0];
            if (we_i[QB_VEC])    vec_o          <= vec_clean(wdata[31:16], NUM_VEC);
            if (we_i[QB_EN])     en_o           <= wdata[0];
            if (we_i[QB_DESC_L]) desc_o[31:0]   <= wdata;
            if (we_i[QB_DESC_H]) desc_o[63:32]  <= wdata;
            if (we_i[QB_AVL_L])  avail_o[31:0]  <= wdata;
            if (we_i[QB_AVL_H])  avail_o[63:32] <= wdata;
            if (we_i[QB_USD_L])  used_o[31:0]   <= wdata;
            if (we_i[QB_USD_H])  used_o[63:32]  <= wdata;
        end
    end

    // R4
    size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(size_o) <= 1) && ({16'd0, size_o} <= QMAX));

    // R5
    vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({16'd0, vec_o} < NUM_VEC) || (vec_o == NO_VEC));

endmodule

// File: rtl/vq_queue_bank.sv
// Array of queue slots. Steers the field strobes to the slot named by
// the queue select; a select at or above NQ reaches no slot.
module vq_queue_bank
    import vq_cfg_pkg::*;
#(
    parameter int unsigned NQ      = 4,
    parameter int unsigned QMAX    = 256,
    parameter int unsigned NUM_VEC = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_i,
    input  logic [QF_N-1:0]       we_i,
    input  logic [15:0]           sel_i,
    input  logic [31:0]           wdata,
    output logic [NQ-1:0][15:0]   q_size_o,
    output logic [NQ-1:0][15:0]   q_vec_o,
    output logic [NQ-1:0]         q_en_o,
    output logic [NQ-1:0][63:0]   q_desc_o,
    output logic [NQ-1:0][63:0]   q_avail_o,
    output logic [NQ-1:0][63:0]   q_used_o
);

    for (genvar gi = 0; gi < NQ; gi++) begin : g_slot
        logic [QF_N-1:0] slot_we;
        // Strobes reach this slot only while it is selected
        assign slot_we = (sel_i == 16'(gi)) ? we_i : '0;

        vq_queue_slot #(.QMAX(QMAX), .NUM_VEC(NUM_VEC)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_i   (clr_i),
            .we_i    (slot_we),
            .wdata   (wdata),
            .size_o  (q_size_o[gi]),
            .vec_o   (q_vec_o[gi]),
            .en_o    (q_en_o[gi]),
            .desc_o  (q_desc_o[gi]),
            .avail_o (q_avail_o[gi]),
            .used_o  (q_used_o[gi])
        );
    end

    // R7
    oob_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|we_i) && !clr_i && ({16'd0, sel_i} >= NQ)) |=>
            ($stable(q_size_o) && $stable(q_vec_o) && $stable(q_en_o)));

endmodule

// File: rtl/vq_cfg_regs.sv
// Common configuration register file of a paravirtual PCI function.
// Decodes the register bus, holds status, config vector and queue select,
// and muxes one-cycle read data. Assumes at most one access type per
// word per cycle and 2 <= NQ <= 65535.
module vq_cfg_regs
    import vq_cfg_pkg::*;
#(
    parameter int unsigned NQ       = 4,
    parameter int unsigned QMAX     = 256,
    parameter int unsigned NUM_VEC  = 8,
    parameter logic [63:0] DEV_FEAT = 64'hA5A5_0001_1234_5678
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [5:0]          addr,
    input  logic [31:0]         wdata,
    input  logic [3:0]          be,
    output logic                rd_valid,
    output logic [31:0]         rd_data,
    output logic                dev_reset_o,
    output logic [7:0]          dev_status_o,
    output logic [63:0]         drv_feat_o,
    output logic [15:0]         cfg_vec_o,
    output logic [NQ-1:0][15:0] q_size_o,
    output logic [NQ-1:0][15:0] q_vec_o,
    output logic [NQ-1:0]       q_en_o,
    output logic [NQ-1:0][63:0] q_desc_o,
    output logic [NQ-1:0][63:0] q_avail_o,
    output logic [NQ-1:0][63:0] q_used_o
);

    localparam int          IDX_W = (NQ > 1) ? $clog2(NQ) : 1;
    localparam logic [15:0] QCNT  = 16'(NQ);

    word_e           word;
    logic            full, lo16, hi16;
    logic            sw_rst;
    logic [15:0]     qsel_q;
    logic [IDX_W-1:0] qi;
    logic            qv;
    logic [QF_N-1:0] qwe;
    logic [31:0]     rmux;
    logic [31:0]     dsel_rd, dfeat_rd, gsel_rd, gfeat_rd;

    // Address and natural-width byte-enable decode
    always_comb begin
        word = word_e'(addr[5:2]);
        full = (be == 4'hF);
        lo16 = (be[1:0] == 2'b11);
        hi16 = (be[3:2] == 2'b11);
        qi   = qsel_q[IDX_W-1:0];
        qv   = (qsel_q < QCNT);
    end

    // A zero written into the status byte starts a function reset
    assign sw_rst = wr_en && (word == W_STAT) && be[0] && (wdata[7:0] == 8'd0);

    // Status, queue select, config vector and the reset pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_status_o <= '0;
            qsel_q       <= '0;
            cfg_vec_o    <= NO_VEC;
            dev_reset_o  <= 1'b0;
        end else begin
            dev_reset_o <= sw_rst;
            if (wr_en && word == W_STAT && be[0]) dev_status_o <= wdata[7:0];
            if (wr_en && word == W_STAT && hi16)  qsel_q       <= wdata[31:16];
            if (wr_en && word == W_MISC && lo16)  cfg_vec_o    <= vec_clean(wdata[15:0], NUM_VEC);
        end
    end

    // Per-queue field strobes from the decoded word
    always_comb begin
        qwe = '0;
        if (wr_en) begin
            unique case (word)
                W_QSZV: begin
                    qwe[QB_SIZE] = lo16;
                    qwe[QB_VEC]  = hi16;
                end
                W_QENO:   qwe[QB_EN]     = lo16;
                W_DESC_L: qwe[QB_DESC_L] = full;
                W_DESC_H: qwe[QB_DESC_H] = full;
                W_AVL_L:  qwe[QB_AVL_L]  = full;
                W_AVL_H:  qwe[QB_AVL_H]  = full;
                W_USD_L:  qwe[QB_USD_L]  = full;
                W_USD_H:  qwe[QB_USD_H]  = full;
                default:  qwe = '0;
            endcase
        end
    end

    vq_feature_window #(.DEV_FEAT(DEV_FEAT)) u_feat (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (sw_rst),
        .dsel_we    (wr_en && word == W_DFSEL && full),
        .gsel_we    (wr_en && word == W_GFSEL && full),
        .gfeat_we   (wr_en && word == W_GFEAT && full),
        .wdata      (wdata),
        .dsel_rd    (dsel_rd),
        .dfeat_rd   (dfeat_rd),
        .gsel_rd    (gsel_rd),
        .gfeat_rd   (gfeat_rd),
        .drv_feat_o (drv_feat_o)
    );

    vq_queue_bank #(.NQ(NQ), .QMAX(QMAX), .NUM_VEC(NUM_VEC)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (sw_rst),
        .we_i      (qwe),
        .sel_i     (qsel_q),
        .wdata     (wdata),
        .q_size_o  (q_size_o),
        .q_vec_o   (q_vec_o),
        .q_en_o    (q_en_o),
        .q_desc_o  (q_desc_o),
        .q_avail_o (q_avail_o),
        .q_used_o  (q_used_o)
    );

    // Read data selection for the addressed word
    always_comb begin
        rmux = '0;
        unique case (word)
            W_DFSEL:  rmux = dsel_rd;
            W_DFEAT:  rmux = dfeat_rd;
            W_GFSEL:  rmux = gsel_rd;
            W_GFEAT:  rmux = gfeat_rd;
            W_MISC:   rmux = {QCNT, cfg_vec_o};
            W_STAT:   rmux = {qsel_q, 8'd0, dev_status_o};
            W_QSZV:   rmux = qv ? {q_vec_o[qi], q_size_o[qi]} : 32'd0;
            W_QENO:   rmux = qv ? {{(16-IDX_W){1'b0}}, qi, 15'd0, q_en_o[qi]} : 32'd0;
            W_DESC_L: rmux = qv ? q_desc_o[qi][31:0]   : 32'd0;
            W_DESC_H: rmux = qv ? q_desc_o[qi][63:32]  : 32'd0;
            W_AVL_L:  rmux = qv ? q_avail_o[qi][31:0]  : 32'd0;
            W_AVL_H:  rmux = qv ? q_avail_o[qi][63:32] : 32'd0;
            W_USD_L:  rmux = qv ? q_used_o[qi][31:0]   : 32'd0;
            W_USD_H:  rmux = qv ? q_used_o[qi][63:32]  : 32'd0;
            default:  rmux = '0;
        endcase
    end

    // Registered read return, one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= rmux;
        end
    end

    // R9
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (dev_reset_o && dev_status_o == 8'd0 && q_en_o == '0
                    && drv_feat_o == 64'd0));

    // R11
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R11
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

endmodule

// File: tb/vq_cfg_regs_test.sv
`timescale 1ns/100ps
// Scoreboard bench: read tasks queue expected words, a monitor compares
// them when rd_valid returns; port checks follow each write.
module vq_cfg_regs_test;

    localparam int unsigned NQ      = 4;
    localparam int unsigned QMAX    = 256;
    localparam int unsigned NUM_VEC = 8;
    localparam logic [63:0] FEAT    = 64'hA5A5_0001_1234_5678;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                wr_en = 1'b0, rd_en = 1'b0;
    logic [5:0]          addr = '0;
    logic [31:0]         wdata = '0;
    logic [3:0]          be = '0;
    logic                rd_valid, dev_reset_o;
    logic [31:0]         rd_data;
    logic [7:0]          dev_status_o;
    logic [63:0]         drv_feat_o;
    logic [15:0]         cfg_vec_o;
    logic [NQ-1:0][15:0] q_size_o, q_vec_o;
    logic [NQ-1:0]       q_en_o;
    logic [NQ-1:0][63:0] q_desc_o, q_avail_o, q_used_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    vq_cfg_regs #(.NQ(NQ), .QMAX(QMAX), .NUM_VEC(NUM_VEC), .DEV_FEAT(FEAT)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .be(be), .rd_valid(rd_valid), .rd_data(rd_data),
        .dev_reset_o(dev_reset_o), .dev_status_o(dev_status_o),
        .drv_feat_o(drv_feat_o), .cfg_vec_o(cfg_vec_o), .q_size_o(q_size_o),
        .q_vec_o(q_vec_o), .q_en_o(q_en_o), .q_desc_o(q_desc_o),
        .q_avail_o(q_avail_o), .q_used_o(q_used_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Write one word; returns at the falling edge after it has landed
    task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] b);
        wr_en = 1'b1; addr = a; wdata = d; be = b;
        @(negedge clk);
        wr_en = 1'b0; be = '0;
    endtask

    // Read one word; the expected value goes to the scoreboard
    task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.exp = e; it.tag = tag;
        sb.push_back(it);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Monitor: compare each returned word with the oldest expectation
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (sb.size() == 0) begin
                checks++; failures++;
                $display("FAIL R11 unexpected rd_valid actual=%h expected=none", rd_data);
            end else begin
                item_t it;
                it = sb.pop_front();
                chk(it.tag, {32'd0, rd_data}, {32'd0, it.exp});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk("R12 status", {56'd0, dev_status_o}, 64'd0);
        chk("R12 enables", {60'd0, q_en_o}, 64'd0);
        chk("R12 size", {48'd0, q_size_o[0]}, 64'd256);
        chk("R12 pulse", {63'd0, dev_reset_o}, 64'd0);
        chk("R11 idle", {63'd0, rd_valid}, 64'd0);
        rd(6'h10, 32'h0004_FFFF, "R8 R5 count and reset vector");
        rd(6'h18, 32'hFFFF_0100, "R12 queue0 size/vector");

        // R2 offered features through the select window
        wr(6'h00, 32'd0, 4'hF);
        rd(6'h04, 32'h1234_5678, "R2 low half");
        wr(6'h00, 32'd1, 4'hF);
        rd(6'h04, 32'hA5A5_0001, "R2 high half");
        wr(6'h00, 32'd2, 4'hF);
        rd(6'h04, 32'd0, "R2 invalid select");

        // R3 accepted features
        wr(6'h08, 32'd0, 4'hF);
        wr(6'h0C, 32'hDEAD_BEEF, 4'hF);
        wr(6'h08, 32'd1, 4'hF);
        wr(6'h0C, 32'h1234_5678, 4'hF);
        rd(6'h0C, 32'h1234_5678, "R3 high half readback");
        chk("R3 port", drv_feat_o, 64'h1234_5678_DEAD_BEEF);
        wr(6'h08, 32'd5, 4'hF);
        wr(6'h0C, 32'hFFFF_FFFF, 4'hF);
        chk("R3 dropped write", drv_feat_o, 64'h1234_5678_DEAD_BEEF);
        rd(6'h0C, 32'd0, "R3 invalid select reads zero");
        rd(6'h08, 32'd5, "R1 select readback");

        // R6 R8 select queue 2 (high half only, status untouched)
        wr(6'h14, 32'h0002_0000, 4'b1100);
        chk("R10 status untouched", {56'd0, dev_status_o}, 64'd0);
        rd(6'h1C, 32'h0002_0000, "R8 notify offset 2");

        // R4 size rules
        wr(6'h18, 32'h0000_0040, 4'b0011);
        rd(6'h18, 32'hFFFF_0040, "R4 size 64");
        chk("R6 size port q2", {48'd0, q_size_o[2]}, 64'd64);
        chk("R6 size port q0", {48'd0, q_size_o[0]}, 64'd256);
        wr(6'h18, 32'h0000_0064, 4'b0011);
        rd(6'h18, 32'hFFFF_0040, "R4 non power of two ignored");
        wr(6'h18, 32'h0000_0200, 4'b0011);
        rd(6'h18, 32'hFFFF_0040, "R4 above max ignored");
        wr(6'h18, 32'h0000_0000, 4'b0011);
        rd(6'h18, 32'hFFFF_0000, "R4 zero accepted");

        // R5 R10 both halves, then vector clamp, then partial enable
        wr(6'h18, 32'h0003_0080, 4'hF);
        rd(6'h18, 32'h0003_0080, "R5 vector 3 size 128");
        wr(6'h18, 32'h0009_0000, 4'b1100);
        rd(6'h18, 32'hFFFF_0080, "R5 vector out of range");
        wr(6'h18, 32'h0000_0010, 4'b0001);
        rd(6'h18, 32'hFFFF_0080, "R10 partial enable ignored");

        // R6 enable and ring addresses
        wr(6'h1C, 32'h0000_0001, 4'b0011);
        chk("R6 enable port", {60'd0, q_en_o}, 64'h4);
        wr(6'h20, 32'h1000_0000, 4'hF);
        wr(6'h24, 32'h0000_0001, 4'hF);
        chk("R6 desc port", q_desc_o[2], 64'h0000_0001_1000_0000);
        rd(6'h24, 32'h0000_0001, "R6 desc high readback");
        wr(6'h28, 32'hABCD_0000, 4'hF);
        rd(6'h28, 32'hABCD_0000, "R6 avail low readback");
        wr(6'h34, 32'h0000_0077, 4'hF);
        chk("R6 used port", q_used_o[2], 64'h0000_0077_0000_0000);
        rd(6'h38, 32'd0, "R1 unmapped word");

        // R7 select beyond the queue count
        wr(6'h14, 32'h0004_0000, 4'b1100);
        rd(6'h18, 32'd0, "R7 size reads zero");
        wr(6'h18, 32'h0000_0020, 4'b0011);
        chk("R7 q3 size", {48'd0, q_size_o[3]}, 64'd256);
        chk("R7 q2 size", {48'd0, q_size_o[2]}, 64'd128);

        // R5 config vector
        wr(6'h10, 32'h0000_0007, 4'b0011);
        rd(6'h10, 32'h0004_0007, "R5 config vector 7");
        wr(6'h10, 32'h0000_0800, 4'b0011);
        rd(6'h10, 32'h0004_FFFF, "R5 config vector clamp");
        wr(6'h10, 32'h0000_0005, 4'b0011);

        // R9 nonzero status, then function reset
        wr(6'h14, 32'h0000_000F, 4'b0001);
        chk("R9 status stored", {56'd0, dev_status_o}, 64'h0F);
        chk("R9 no pulse on nonzero", {63'd0, dev_reset_o}, 64'd0);
        rd(6'h14, 32'h0004_000F, "R1 status word");
        wr(6'h14, 32'h0000_0000, 4'b0001);
        chk("R9 pulse", {63'd0, dev_reset_o}, 64'd1);
        chk("R9 status clear", {56'd0, dev_status_o}, 64'd0);
        chk("R9 enables clear", {60'd0, q_en_o}, 64'd0);
        chk("R9 size restored", {48'd0, q_size_o[2]}, 64'd256);
        chk("R9 vector restored", {48'd0, q_vec_o[2]}, 64'hFFFF);
        chk("R9 desc clear", q_desc_o[2], 64'd0);
        chk("R9 features clear", drv_feat_o, 64'd0);
        chk("R9 config vector kept", {48'd0, cfg_vec_o}, 64'd5);
        @(negedge clk);
        chk("R9 pulse one cycle", {63'd0, dev_reset_o}, 64'd0);
        chk("R11 idle after reads", {63'd0, rd_valid}, 64'd0);

        repeat (3) @(negedge clk);
        chk("R11 scoreboard drained", 64'(sb.size()), 64'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule